// File: doc/BRIEF.md
# Prioritized Tone Slot Scanner

This block is the control and status logic that sits around a multi-slot sub-audio or selective-call tone detector. A host fills up to fifteen tone slots with frequency codes through a small synchronous register port. It then picks which slots take part and starts the scanner. Each scan pass offers the enabled slots to an external detector one at a time, in ascending slot order. Every slot is held for a fixed number of cycles. The detector's hit line is sampled on the last of those cycles.

The first slot that reports a hit ends the pass. When two detector bands overlap, the lower-numbered slot is therefore the one reported. At the end of every pass the result is compared with the result of the previous pass. A difference updates a status register and raises a tone-change flag. That flag drives an interrupt output through a mask bit. The host reads the flag register to clear the flag.

Top module: `tone_slot_scanner`

## Requirements
- R1: After a synchronous active-low reset the following read as zero: status, tone-change flag, mask, control and all slot enables. `irq` and `det_valid` are low.
- R2: Addresses 0x00 to 0x0E hold the frequency codes of slots 0 to 14. Codes may be in any order and read back as written. While a slot is being presented, `det_freq` carries that slot's code.
- R3: A pass presents only the enabled slots, in ascending slot order. Address 0x11 bit n enables slot n for n = 0..7. Address 0x12 bit n-8 enables slot n for n = 8..14. Each presented slot keeps `det_valid` high with a steady `det_slot` for exactly DWELL_CYC cycles.
- R4: `det_hit` is sampled on the last cycle of a slot's dwell. A hit ends the pass at once, and no higher slot is presented in that pass. The lowest matching slot is therefore reported.
- R5: The status register at address 0x13 gives the last pass result. Bit 4 is tone present and bits 3:0 are the matching slot number. A pass with no hit gives 0x00.
- R6: The tone-change flag is bit 3 of address 0x15. It is set when a pass result differs from the previous one: a tone appears, a tone goes away, or the tone moves to another slot. A pass that repeats the previous result leaves the flag alone.
- R7: `irq` is high exactly when the tone-change flag is set and mask bit 3 of address 0x14 is set.
- R8: Reading address 0x15 returns the flag as it was and clears it. If a change arrives in the same cycle as that read, the flag stays set.
- R9: Scanning runs only while control bit 0 at address 0x10 is 1. When it is 0, `det_valid` stays low and the status and the flag do not change.
- R10: A read presents its data on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| det_valid | output | 1 | A slot is being presented to the detector |
| det_slot | output | 4 | Slot number being presented |
| det_freq | output | FREQ_W | Frequency code of the presented slot |
| det_hit | input | 1 | Detector match, sampled on the last dwell cycle |
| irq | output | 1 | Masked tone-change interrupt |

## Verification
Two things can happen in the same clock edge: a pass committing a new result, and a host read that clears the tone-change flag. The bench provokes this with a single enabled slot whose tone is already present. It waits for `det_valid` to rise and counts off the dwell cycles. It then issues the flag read on the final dwell cycle, the cycle whose edge commits the hit. That read must return the old, cleared flag, and the read after it must still find bit 3 set. Only a third read may return zero.

// File: rtl/tss_pkg.sv
// Package: shared register offsets and the pass result type of the tone
// slot scanner. Assumes a register data width of at least 8 bits.
package tss_pkg;
    localparam int SLOT_W       = 4;
    localparam int ADR_CTRL     = 16;
    localparam int ADR_EN_LO    = 17;
    localparam int ADR_EN_HI    = 18;
    localparam int ADR_STATUS   = 19;
    localparam int ADR_MASK     = 20;
    localparam int ADR_FLAG     = 21;
    localparam int IRQ_TONE_BIT = 3;

    typedef struct packed {
        logic              present;
        logic [SLOT_W-1:0] slot;
    } tone_result_t;
endpackage

// File: rtl/tss_regfile.sv
// Register file: holds slot codes, slot enables, control and mask, and
// returns registered read data. Assumes DATA_W >= 8 and FREQ_W <= DATA_W.
module tss_regfile
    import tss_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int FREQ_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  tone_result_t                status,
    input  logic                        irq_flag,
    output logic [DATA_W-1:0]           rdata,
    output logic                        scan_en,
    output logic                        irq_mask,
    output logic                        flag_rd,
    output logic [NUM_SLOTS-1:0]        slot_en,
    output logic [NUM_SLOTS*FREQ_W-1:0] slot_freq
);
    logic [FREQ_W-1:0] freq_q [NUM_SLOTS];
    logic [DATA_W-1:0] rd_mux;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int EN_ADR = ADR_EN_LO + i / 8;
        localparam int EN_BIT = i % 8;

        // Store this slot's frequency code on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                freq_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))
                freq_q[i] <= wdata[FREQ_W-1:0];
        end

        // Store this slot's enable bit from its enable byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_en[i] <= 1'b0;
            else if (wr_en && addr == ADDR_W'(EN_ADR))
                slot_en[i] <= wdata[EN_BIT];
        end

        assign slot_freq[i*FREQ_W +: FREQ_W] = freq_q[i];
    end

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_en  <= 1'b0;
            irq_mask <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_CTRL)) scan_en  <= wdata[0];
            if (addr == ADDR_W'(ADR_MASK)) irq_mask <= wdata[IRQ_TONE_BIT];
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (addr == ADDR_W'(i))
                rd_mux[FREQ_W-1:0] = freq_q[i];
            if (addr == ADDR_W'(ADR_EN_LO + i / 8))
                rd_mux[i % 8] = slot_en[i];
        end
        if (addr == ADDR_W'(ADR_CTRL))   rd_mux[0] = scan_en;
        if (addr == ADDR_W'(ADR_STATUS)) rd_mux[SLOT_W:0] = status;
        if (addr == ADDR_W'(ADR_MASK))   rd_mux[IRQ_TONE_BIT] = irq_mask;
        if (addr == ADDR_W'(ADR_FLAG))   rd_mux[IRQ_TONE_BIT] = irq_flag;
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign flag_rd = rd_en && (addr == ADDR_W'(ADR_FLAG));
endmodule

// File: rtl/tss_sequencer.sv
// Slot walker: steps through the enabled slots in ascending order, holds
// each for DWELL_CYC cycles and samples the detector on the last one.
// Assumes that det_hit is valid in the final dwell cycle of the slot.
module tss_sequencer
    import tss_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int FREQ_W    = 8,
    parameter int DWELL_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scan_en,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    input  logic [NUM_SLOTS*FREQ_W-1:0] slot_freq,
    input  logic                        det_hit,
    output logic                        det_valid,
    output logic [SLOT_W-1:0]           det_slot,
    output logic [FREQ_W-1:0]           det_freq,
    output logic                        pass_done,
    output logic                        pass_hit,
    output logic [SLOT_W-1:0]           pass_slot
);
    localparam int CNT_W = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;

    typedef enum logic { ST_IDLE, ST_DWELL } seq_state_t;

    seq_state_t        state;
    logic [SLOT_W-1:0] cur;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic              first_any, next_any;
    logic [SLOT_W-1:0] first_idx, next_idx;

    // Find the lowest enabled slot overall and the lowest one above cur.
    always_comb begin
        first_any = 1'b0;
        first_idx = '0;
        next_any  = 1'b0;
        next_idx  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_en[i]) begin
                first_any = 1'b1;
                first_idx = SLOT_W'(i);
                if (SLOT_W'(i) > cur) begin
                    next_any = 1'b1;
                    next_idx = SLOT_W'(i);
                end
            end
        end
    end

    // Route the current slot's frequency code to the detector.
    always_comb begin
        det_freq = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (cur == SLOT_W'(i))
                det_freq = slot_freq[i*FREQ_W +: FREQ_W];
    end

    assign last      = (cnt == CNT_W'(DWELL_CYC - 1));
    assign det_valid = (state == ST_DWELL);
    assign det_slot  = cur;
    assign pass_hit  = scan_en && det_valid && last && det_hit;
    assign pass_slot = cur;
    assign pass_done = scan_en &&
                       ((state == ST_IDLE && !first_any) ||
                        (det_valid && last && (det_hit || !next_any)));

    // Walk the slots; abort without a result when scanning is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            cnt   <= '0;
        end else if (!scan_en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (first_any) begin
                state <= ST_DWELL;
                cur   <= first_idx;
                cnt   <= '0;
            end
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end else if (det_hit || !next_any) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            cur <= next_idx;
            cnt <= '0;
        end
    end

    a_r3_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && cnt != '0) |-> (det_slot == $past(det_slot)));
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && cnt == '0 && $past(det_valid)) |-> (det_slot > $past(det_slot)));
    a_r4_hit_ends_pass: assert property (@(posedge clk) disable iff (!rst_n)
        pass_hit |=> !det_valid);
    a_r9_stop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> !det_valid);
endmodule

// File: rtl/tss_result.sv
// Result keeper: compares each pass result with the previous one, updates
// the status word and manages the read-to-clear tone-change flag.
module tss_result
    import tss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_done,
    input  logic              pass_hit,
    input  logic [SLOT_W-1:0] pass_slot,
    input  logic              flag_rd,
    output tone_result_t      status,
    output logic              irq_flag
);
    tone_result_t new_res;
    logic         change;

    // Form the result of the finishing pass; slot is zero with no tone.
    always_comb begin
        new_res.present = pass_hit;
        new_res.slot    = pass_hit ? pass_slot : '0;
    end

    assign change = pass_done && (new_res != status);

    // Keep the latest pass result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (pass_done)
            status <= new_res;
    end

    // Set on change, clear on read; a change in the read cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (change)
            irq_flag <= 1'b1;
        else if (flag_rd)
            irq_flag <= 1'b0;
    end

    a_r5_absent_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status.present |-> (status.slot == '0));
    a_r6_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> irq_flag);
    a_r6_quiet_between_passes: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_done |=> $stable(status));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (change && flag_rd) |=> irq_flag);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !change) |=> !irq_flag);
endmodule

// File: rtl/tone_slot_scanner.sv
// Top level: register port, slot walker and result keeper of the
// prioritized tone slot scanner. The detector itself is external.
module tone_slot_scanner
    import tss_pkg::*;
#(
    parameter int NUM_SLOTS = 15,
    parameter int FREQ_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int DWELL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              det_valid,
    output logic [3:0]        det_slot,
    output logic [FREQ_W-1:0] det_freq,
    input  logic              det_hit,
    output logic              irq
);
    logic                        scan_en, irq_mask, flag_rd, irq_flag;
    logic [NUM_SLOTS-1:0]        slot_en;
    logic [NUM_SLOTS*FREQ_W-1:0] slot_freq;
    logic                        pass_done, pass_hit;
    logic [SLOT_W-1:0]           pass_slot;
    tone_result_t                status;

    tss_regfile #(
        .NUM_SLOTS(NUM_SLOTS), .FREQ_W(FREQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .status(status), .irq_flag(irq_flag), .rdata(rdata),
        .scan_en(scan_en), .irq_mask(irq_mask), .flag_rd(flag_rd),
        .slot_en(slot_en), .slot_freq(slot_freq)
    );

    tss_sequencer #(
        .NUM_SLOTS(NUM_SLOTS), .FREQ_W(FREQ_W), .DWELL_CYC(DWELL_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .slot_en(slot_en),
        .slot_freq(slot_freq), .det_hit(det_hit), .det_valid(det_valid),
        .det_slot(det_slot), .det_freq(det_freq), .pass_done(pass_done),
        .pass_hit(pass_hit), .pass_slot(pass_slot)
    );

    tss_result u_res (
        .clk(clk), .rst_n(rst_n), .pass_done(pass_done), .pass_hit(pass_hit),
        .pass_slot(pass_slot), .flag_rd(flag_rd), .status(status),
        .irq_flag(irq_flag)
    );

    assign irq = irq_flag && irq_mask;

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);
endmodule

// File: tb/tb_tone_slot_scanner.sv
`timescale 1ns/1ps
module tb_tone_slot_scanner;
    localparam int DWELL   = 4;
    localparam int A_CTRL  = 16, A_ENLO = 17, A_ENHI = 18;
    localparam int A_STAT  = 19, A_MASK = 20, A_FLAG = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       det_valid, det_hit, irq;
    logic [3:0] det_slot;
    logic [7:0] det_freq;

    logic [14:0] tone_map = '0;
    logic [7:0]  prog_freq [15];
    logic [7:0]  exp_q [$];
    logic [3:0]  visit_q [$];
    bit          chk_dwell = 1'b0;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign det_hit = det_valid && tone_map[det_slot];

    tone_slot_scanner #(.DWELL_CYC(DWELL)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .det_valid(det_valid),
        .det_slot(det_slot), .det_freq(det_freq), .det_hit(det_hit), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(int a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Driver side of the scoreboard: queue an expected status word.
    task automatic push_exp(logic [7:0] v);
        exp_q.push_back(v);
    endtask

    // Compare the next queued status word with the status register.
    task automatic check_status(string req);
        logic [7:0] v;
        reg_rd(A_STAT, v);
        check(req, v, exp_q.pop_front());
    endtask

    // Monitor: dwell lengths, visit order and presented frequency codes.
    logic       prev_valid = 1'b0;
    logic [3:0] prev_slot = '0;
    int         run = 0;
    always @(negedge clk) begin
        if (det_valid && (!prev_valid || det_slot != prev_slot)) begin
            if (prev_valid && chk_dwell) check("R3 dwell length", run, DWELL);
            visit_q.push_back(det_slot);
            check("R2 det_freq", det_freq, prog_freq[det_slot]);
            run = 1;
        end else if (det_valid) begin
            run++;
        end else if (prev_valid && chk_dwell) begin
            check("R3 dwell length", run, DWELL);
        end
        prev_valid = det_valid;
        prev_slot  = det_slot;
    end

    task automatic wait_passes();
        repeat (200) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        bit         high_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 det_valid", det_valid, 0);
        reg_rd(A_FLAG, v); check("R1 flag", v, 0);
        reg_rd(A_CTRL, v); check("R1 ctrl", v, 0);
        reg_rd(A_ENLO, v); check("R1 enables", v, 0);
        push_exp(8'h00); check_status("R1 status");

        // R2: descending codes in ascending slots, read back
        for (int i = 0; i < 15; i++) begin
            prog_freq[i] = 8'(8'hF0 - i * 9);
            reg_wr(i, prog_freq[i]);
        end
        reg_rd(0, v);  check("R2 readback slot0", v, prog_freq[0]);
        reg_rd(7, v);  check("R2 readback slot7", v, prog_freq[7]);
        reg_rd(14, v); check("R10 readback slot14", v, prog_freq[14]);

        // R3: slots 2, 5, 9, 14 enabled; order from the first pass
        reg_wr(A_ENLO, 8'h24);
        reg_wr(A_ENHI, 8'h42);
        reg_wr(A_MASK, 8'h08);
        visit_q.delete();
        chk_dwell = 1'b1;
        reg_wr(A_CTRL, 8'h01);
        wait_passes();
        check("R3 visit 0", visit_q[0], 2);
        check("R3 visit 1", visit_q[1], 5);
        check("R3 visit 2", visit_q[2], 9);
        check("R3 visit 3", visit_q[3], 14);
        check("R3 visit 4", visit_q[4], 2);
        push_exp(8'h00); check_status("R5 no tone");
        reg_rd(A_FLAG, v); check("R6 no change", v, 0);

        // R4: slots 5 and 9 both hear a tone; 5 wins, 9 never presented
        tone_map = 15'h0220;
        wait_passes();
        check("R7 irq raised", irq, 1);
        visit_q.delete();
        wait_passes();
        high_seen = 1'b0;
        foreach (visit_q[k]) if (visit_q[k] > 5) high_seen = 1'b1;
        check("R4 pass ends at hit", high_seen, 0);
        push_exp(8'h15); check_status("R4 R5 lowest slot");
        reg_rd(A_FLAG, v); check("R6 flag on appear", v, 8'h08);
        @(negedge clk);
        check("R8 irq after read", irq, 0);
        reg_rd(A_FLAG, v); check("R8 flag cleared", v, 0);

        // R6: same result repeats; no new flag
        wait_passes();
        reg_rd(A_FLAG, v); check("R6 repeat quiet", v, 0);

        // R6: tone moves to slot 14
        tone_map = 15'h4000;
        wait_passes();
        push_exp(8'h1E); check_status("R6 switch slot");
        reg_rd(A_FLAG, v); check("R6 flag on switch", v, 8'h08);

        // R7: masked flag does not drive irq
        reg_wr(A_MASK, 8'h00);
        tone_map = '0;
        wait_passes();
        check("R7 masked irq", irq, 0);
        push_exp(8'h00); check_status("R6 tone gone");
        reg_rd(A_FLAG, v); check("R7 flag still set", v, 8'h08);

        // R9: scanning off freezes everything
        chk_dwell = 1'b0;
        reg_wr(A_CTRL, 8'h00);
        @(negedge clk);
        tone_map = 15'h0004;
        high_seen = 1'b0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (det_valid) high_seen = 1'b1;
        end
        check("R9 det_valid low", high_seen, 0);
        push_exp(8'h00); check_status("R9 status frozen");
        reg_rd(A_FLAG, v); check("R9 flag frozen", v, 0);

        // R8: flag read lands on the commit edge of a hit on slot 3
        tone_map = 15'h0008;
        reg_wr(A_ENLO, 8'h08);
        reg_wr(A_ENHI, 8'h00);
        reg_wr(A_MASK, 8'h08);
        chk_dwell = 1'b1;
        reg_wr(A_CTRL, 8'h01);
        do @(negedge clk); while (!det_valid);
        repeat (DWELL - 1) @(negedge clk);
        rd_en = 1'b1; addr = 5'(A_FLAG);
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 read returns old flag", rdata, 0);
        check("R8 irq with set", irq, 1);
        reg_rd(A_FLAG, v); check("R8 set wins", v, 8'h08);
        reg_rd(A_FLAG, v); check("R8 clear after", v, 0);
        push_exp(8'h13); check_status("R5 slot 3");

        finish_run();
    end
endmodule